// File: doc/BRIEF.md
# ADC Power-Up and Calibration Sequencer

This block is the control layer above a serial transaction engine for a multi-channel sigma-delta converter. After reset it sends the converter a serial-interface reset. It waits out the mandatory settling time and reads the identity register to learn whether the part has 16-bit or 24-bit results. It then loads the mode, configuration and excitation-current settings taken from static parameter inputs. Last, it runs an internal zero-scale and full-scale calibration on every differential input.

Once calibration is done the block raises `ready`. It then accepts single-conversion requests for any channel code and returns the result. It also accepts gain-change requests. A gain that differs from the current one is written to the converter and starts a complete recalibration. Each converter access is handed to the engine as one transaction: a kind, a register address, a byte count and write data. The engine answers with a one-cycle acknowledge, which can carry an error flag. The converter's ready line is sampled as `rdy_n` (active low).

Top module: `adc_cal_seq`

## Requirements
- R1: The first transaction has kind 0 (interface reset, byte count 0). The next transaction does not start until at least ceil(CLK_HZ/2000) clock cycles after the reset transaction is acknowledged.
- R2: The second transaction reads the identity register (kind 2, address 4, one byte). A low nibble of 0xA gives `wide`=0 (16-bit results). A low nibble of 0xB gives `wide`=1 (24-bit results). Any other value enters the fault state and issues no further transaction.
- R3: The settings then load in this order. First the mode word is written to address 1 (2 bytes), with bits 15:13 set to 2 (idle) and all other bits taken from `cfg_mode`. Next the configuration word is written to address 2 (2 bytes), with bits 2:0 cleared. Last `cfg_io` is written to address 5 (1 byte). Write data sits in the low bits of `txn_wdata`.
- R4: Calibration has six steps. Mode code 4 (internal zero-scale) and then code 5 (internal full-scale) are run on channel 0, then on channel 1, then on channel 2.
- R5: Each calibration step does four things in order. It writes the configuration word with bits 2:0 set to the step's channel. It writes the mode word with the calibration code in bits 15:13. It waits for `rdy_n` low. It then writes the mode word with code 2 (idle) in bits 15:13.
- R6: A conversion request (`conv_req` with `conv_chan`) does four things in order. It writes the configuration word with the channel in bits 2:0. It writes the mode word with code 1 (single) in bits 15:13. It waits for `rdy_n` low. It reads address 3 with 3 bytes if `wide` is 1, or 2 bytes otherwise. `conv_done` then pulses for one cycle, and `conv_data` holds the read data, masked to 16 bits when `wide` is 0.
- R7: A gain request whose `gain_val` differs from configuration bits 10:8 writes the configuration word with the new gain in those bits and then repeats the full R4 calibration. A request with an equal gain issues no transaction.
- R8: An acknowledge with `txn_err` high enters the fault state. So does a missing acknowledge, or a missing `rdy_n` low, within TMO_CYC cycles. In the fault state `fault` is 1, `ready` is 0 and no transaction is issued. Only reset leaves the fault state.
- R9: `ready` is 1 only while requests are accepted, and no transaction is in flight then. Conversion or gain requests made while `ready` is 0 are ignored.
- R10: While `txn_valid` is high and no acknowledge has arrived, the kind, address, byte count and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 16 | Mode word settings (select field is overridden) |
| cfg_conf | input | 16 | Configuration word settings (channel field is overridden) |
| cfg_io | input | 8 | Excitation-current register value |
| conv_req | input | 1 | Request one conversion (taken while ready) |
| conv_chan | input | 3 | Channel code for the conversion |
| gain_req | input | 1 | Request a gain setting (taken while ready) |
| gain_val | input | 3 | Requested gain code |
| rdy_n | input | 1 | Converter ready line, active low |
| txn_done | input | 1 | Engine acknowledge, one cycle |
| txn_err | input | 1 | Error flag qualified by txn_done |
| txn_rdata | input | 24 | Read data from the engine, right aligned |
| txn_valid | output | 1 | Transaction request |
| txn_kind | output | 2 | 0 interface reset, 1 write, 2 read |
| txn_addr | output | 3 | Register address |
| txn_bytes | output | 2 | Data byte count |
| txn_wdata | output | 24 | Write data, right aligned |
| ready | output | 1 | Accepting requests |
| fault | output | 1 | Sticky fault state |
| wide | output | 1 | 24-bit variant detected |
| conv_done | output | 1 | Conversion result valid, one cycle |
| conv_data | output | 24 | Conversion result |

## Verification
The hardest situations to reach from the ports are the fault exits. The converter's ready line must never fall after a calibration command, or the engine must report an error partway through the start-up sequence. The bench's engine model can hold `rdy_n` high for one run and can inject an error on a chosen transaction index. A third run returns an identity value that is not recognised. Each case is checked against the exact prefix of transactions expected before the fault. A further corner is a gain-change request that overlaps a conversion request while recalibration has just begun. The bench issues the conversion request in the first busy cycle and confirms that the transaction log contains only the recalibration.

// File: rtl/acs_pkg.sv
package acs_pkg;
  localparam logic [1:0] K_RST = 2'd0;
  localparam logic [1:0] K_WR  = 2'd1;
  localparam logic [1:0] K_RD  = 2'd2;

  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_CONF = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_ID   = 3'd4;
  localparam logic [2:0] A_IO   = 3'd5;

  localparam logic [2:0] SEL_SINGLE = 3'd1;
  localparam logic [2:0] SEL_IDLE   = 3'd2;
  localparam logic [2:0] SEL_CALZ   = 3'd4;
  localparam logic [2:0] SEL_CALF   = 3'd5;

  typedef enum logic [4:0] {
    S_BOOT, S_IFRST, S_DELAY, S_ID, S_LMODE, S_LCONF, S_LIO,
    S_CCONF, S_CMODE, S_CWAIT, S_CIDLE, S_READY,
    S_VCONF, S_VMODE, S_VWAIT, S_VREAD, S_GCONF, S_FAULT
  } seq_state_e;

  // operating-mode select lives in mode bits 15:13
  function automatic logic [15:0] with_sel(logic [15:0] w, logic [2:0] c);
    logic [15:0] r;
    r = w;
    r[15:13] = c;
    return r;
  endfunction

  // input channel lives in configuration bits 2:0
  function automatic logic [15:0] with_chan(logic [15:0] w, logic [2:0] c);
    logic [15:0] r;
    r = w;
    r[2:0] = c;
    return r;
  endfunction

  // gain code lives in configuration bits 10:8
  function automatic logic [15:0] with_gain(logic [15:0] w, logic [2:0] g);
    logic [15:0] r;
    r = w;
    r[10:8] = g;
    return r;
  endfunction

  function automatic logic id_known(logic [7:0] id);
    return (id[3:0] == 4'hA) || (id[3:0] == 4'hB);
  endfunction

  function automatic logic id_wide(logic [7:0] id);
    return id[3:0] == 4'hB;
  endfunction
endpackage

// File: rtl/acs_timer.sv
module acs_timer #(
  parameter int TW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] load,
  output logic          done
);
  logic [TW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      armed <= 1'b0;
    end else if (start) begin
      cnt   <= load;
      armed <= 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign done = armed && (cnt == '0);
endmodule

// File: rtl/acs_fsm.sv
module acs_fsm
  import acs_pkg::*;
#(
  parameter int CAL_CHANS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_mode,
  input  logic [15:0] cfg_conf,
  input  logic [7:0]  cfg_io,
  input  logic        conv_req,
  input  logic [2:0]  conv_chan,
  input  logic        gain_req,
  input  logic [2:0]  gain_val,
  input  logic        rdy_n,
  input  logic        txn_done,
  input  logic        txn_err,
  input  logic [23:0] txn_rdata,
  input  logic        tmr_done,
  output logic        tmr_start,
  output logic        tmr_dly,
  output logic        txn_valid,
  output logic [1:0]  txn_kind,
  output logic [2:0]  txn_addr,
  output logic [1:0]  txn_bytes,
  output logic [23:0] txn_wdata,
  output logic        ready,
  output logic        fault,
  output logic        wide,
  output logic        conv_done,
  output logic [23:0] conv_data
);
  localparam int STEPS = 2 * CAL_CHANS;
  localparam int SW    = (STEPS > 2) ? $clog2(STEPS) : 1;
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  seq_state_e st, st_n;
  logic [15:0] mode_q, conf_q;
  logic [7:0]  io_q;
  logic [SW-1:0] step;
  logic [2:0]  vchan_q, gain_q;
  logic [2:0]  cal_ch, cal_code;
  logic        txn_ok, txn_bad, wait_st, wait_bad;

  assign cal_ch   = 3'(step >> 1);
  assign cal_code = step[0] ? SEL_CALF : SEL_CALZ;
  assign txn_ok   = txn_valid && txn_done && !txn_err;
  assign txn_bad  = txn_valid && ((txn_done && txn_err) || (!txn_done && tmr_done));
  assign wait_st  = (st == S_CWAIT) || (st == S_VWAIT);
  assign wait_bad = wait_st && rdy_n && tmr_done;

  // transaction fields
  always_comb begin
    txn_valid = 1'b1;
    txn_kind  = K_WR;
    txn_addr  = 3'd0;
    txn_bytes = 2'd2;
    txn_wdata = '0;
    case (st)
      S_IFRST: begin txn_kind = K_RST; txn_bytes = 2'd0; end
      S_ID:    begin txn_kind = K_RD; txn_addr = A_ID; txn_bytes = 2'd1; end
      S_LMODE: begin txn_addr = A_MODE; txn_wdata = {8'h0, mode_q}; end
      S_LCONF: begin txn_addr = A_CONF; txn_wdata = {8'h0, conf_q}; end
      S_LIO:   begin txn_addr = A_IO; txn_bytes = 2'd1; txn_wdata = {16'h0, io_q}; end
      S_CCONF: begin txn_addr = A_CONF; txn_wdata = {8'h0, with_chan(conf_q, cal_ch)}; end
      S_CMODE: begin txn_addr = A_MODE; txn_wdata = {8'h0, with_sel(mode_q, cal_code)}; end
      S_CIDLE: begin txn_addr = A_MODE; txn_wdata = {8'h0, with_sel(mode_q, SEL_IDLE)}; end
      S_VCONF: begin txn_addr = A_CONF; txn_wdata = {8'h0, with_chan(conf_q, vchan_q)}; end
      S_VMODE: begin txn_addr = A_MODE; txn_wdata = {8'h0, with_sel(mode_q, SEL_SINGLE)}; end
      S_VREAD: begin txn_kind = K_RD; txn_addr = A_DATA; txn_bytes = wide ? 2'd3 : 2'd2; end
      S_GCONF: begin txn_addr = A_CONF; txn_wdata = {8'h0, with_gain(conf_q, gain_q)}; end
      default: begin txn_valid = 1'b0; txn_bytes = 2'd0; end
    endcase
  end

  // next state
  always_comb begin
    st_n = st;
    case (st)
      S_BOOT:  st_n = S_IFRST;
      S_IFRST: if (txn_ok) st_n = S_DELAY;
      S_DELAY: if (tmr_done) st_n = S_ID;
      S_ID:    if (txn_ok) st_n = id_known(txn_rdata[7:0]) ? S_LMODE : S_FAULT;
      S_LMODE: if (txn_ok) st_n = S_LCONF;
      S_LCONF: if (txn_ok) st_n = S_LIO;
      S_LIO:   if (txn_ok) st_n = S_CCONF;
      S_CCONF: if (txn_ok) st_n = S_CMODE;
      S_CMODE: if (txn_ok) st_n = S_CWAIT;
      S_CWAIT: if (!rdy_n) st_n = S_CIDLE;
      S_CIDLE: if (txn_ok) st_n = (step == LAST) ? S_READY : S_CCONF;
      S_READY: begin
        if (gain_req) begin
          if (gain_val != conf_q[10:8]) st_n = S_GCONF;
        end else if (conv_req) begin
          st_n = S_VCONF;
        end
      end
      S_VCONF: if (txn_ok) st_n = S_VMODE;
      S_VMODE: if (txn_ok) st_n = S_VWAIT;
      S_VWAIT: if (!rdy_n) st_n = S_VREAD;
      S_VREAD: if (txn_ok) st_n = S_READY;
      S_GCONF: if (txn_ok) st_n = S_CCONF;
      default: st_n = S_FAULT;
    endcase
    if (txn_bad || wait_bad) st_n = S_FAULT;
  end

  assign tmr_start = (st_n != st);
  assign tmr_dly   = (st_n == S_DELAY);
  assign ready     = (st == S_READY);
  assign fault     = (st == S_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_BOOT;
      mode_q    <= '0;
      conf_q    <= '0;
      io_q      <= '0;
      step      <= '0;
      wide      <= 1'b0;
      vchan_q   <= '0;
      gain_q    <= '0;
      conv_done <= 1'b0;
      conv_data <= '0;
    end else begin
      st        <= st_n;
      conv_done <= 1'b0;
      if (txn_ok && txn_kind == K_WR && txn_addr == A_MODE) mode_q <= txn_wdata[15:0];
      if (txn_ok && txn_kind == K_WR && txn_addr == A_CONF) conf_q <= txn_wdata[15:0];
      case (st)
        S_ID: if (txn_ok) begin
          wide   <= id_wide(txn_rdata[7:0]);
          mode_q <= with_sel(cfg_mode, SEL_IDLE);
          conf_q <= with_chan(cfg_conf, 3'd0);
          io_q   <= cfg_io;
        end
        S_CIDLE: if (txn_ok && step != LAST) step <= step + 1'b1;
        S_GCONF: if (txn_ok) step <= '0;
        S_READY: begin
          if (gain_req) gain_q <= gain_val;
          else if (conv_req) vchan_q <= conv_chan;
        end
        S_VREAD: if (txn_ok) begin
          conv_done <= 1'b1;
          conv_data <= wide ? txn_rdata : {8'h0, txn_rdata[15:0]};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int CLK_HZ    = 100_000_000,
  parameter int TMO_CYC   = 100_000,
  parameter int CAL_CHANS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] cfg_mode,
  input  logic [15:0] cfg_conf,
  input  logic [7:0]  cfg_io,
  input  logic        conv_req,
  input  logic [2:0]  conv_chan,
  input  logic        gain_req,
  input  logic [2:0]  gain_val,
  input  logic        rdy_n,
  input  logic        txn_done,
  input  logic        txn_err,
  input  logic [23:0] txn_rdata,
  output logic        txn_valid,
  output logic [1:0]  txn_kind,
  output logic [2:0]  txn_addr,
  output logic [1:0]  txn_bytes,
  output logic [23:0] txn_wdata,
  output logic        ready,
  output logic        fault,
  output logic        wide,
  output logic        conv_done,
  output logic [23:0] conv_data
);
  localparam int DLY_CYC = (CLK_HZ + 1999) / 2000;
  localparam int MAX_CYC = (DLY_CYC > TMO_CYC) ? DLY_CYC : TMO_CYC;
  localparam int TW      = $clog2(MAX_CYC + 1);

  logic          tmr_start, tmr_dly, tmr_done;
  logic [TW-1:0] tmr_load;

  assign tmr_load = tmr_dly ? TW'(DLY_CYC) : TW'(TMO_CYC);

  acs_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(tmr_start), .load(tmr_load), .done(tmr_done)
  );

  acs_fsm #(.CAL_CHANS(CAL_CHANS)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cfg_mode(cfg_mode), .cfg_conf(cfg_conf), .cfg_io(cfg_io),
    .conv_req(conv_req), .conv_chan(conv_chan),
    .gain_req(gain_req), .gain_val(gain_val),
    .rdy_n(rdy_n), .txn_done(txn_done), .txn_err(txn_err), .txn_rdata(txn_rdata),
    .tmr_done(tmr_done), .tmr_start(tmr_start), .tmr_dly(tmr_dly),
    .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_addr(txn_addr),
    .txn_bytes(txn_bytes), .txn_wdata(txn_wdata),
    .ready(ready), .fault(fault), .wide(wide),
    .conv_done(conv_done), .conv_data(conv_data)
  );
endmodule

// File: rtl/acs_chk.sv
module acs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        txn_valid,
  input logic        txn_done,
  input logic        txn_err,
  input logic [1:0]  txn_kind,
  input logic [2:0]  txn_addr,
  input logic [1:0]  txn_bytes,
  input logic [23:0] txn_wdata,
  input logic        ready,
  input logic        fault,
  input logic        conv_done,
  input logic        tmr_done
);
  assert_hold_fields_R10: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && !txn_done |=> txn_valid && $stable(txn_kind) && $stable(txn_addr)
                               && $stable(txn_bytes) && $stable(txn_wdata));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault);

  assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !txn_valid && !ready);

  assert_err_to_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid && txn_done && txn_err |=> fault);

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !txn_valid);

  assert_conv_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |-> $past(txn_valid && txn_done && !txn_err && txn_kind == 2'd2 && txn_addr == 3'd3));

  assert_id_after_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(txn_valid) && txn_kind == 2'd2 && txn_addr == 3'd4 |-> $past(tmr_done));
endmodule

bind adc_cal_seq acs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txn_valid(txn_valid), .txn_done(txn_done),
  .txn_err(txn_err), .txn_kind(txn_kind), .txn_addr(txn_addr),
  .txn_bytes(txn_bytes), .txn_wdata(txn_wdata), .ready(ready), .fault(fault),
  .conv_done(conv_done), .tmr_done(tmr_done)
);

// File: tb/sim_adc_cal_seq.sv
`timescale 1ns/1ps
module sim_adc_cal_seq;
  localparam int HZ  = 100_000;
  localparam int TMO = 300;
  localparam int DLY = (HZ + 1999) / 2000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [15:0] cfg_mode = 16'hE04A;
  logic [15:0] cfg_conf = 16'h0357;
  logic [7:0]  cfg_io   = 8'h0C;
  logic conv_req = 1'b0, gain_req = 1'b0;
  logic [2:0] conv_chan = 3'd0, gain_val = 3'd0;
  logic rdy_n = 1'b1, txn_done = 1'b0, txn_err = 1'b0;
  logic [23:0] txn_rdata = '0;
  logic txn_valid, ready, fault, wide, conv_done;
  logic [1:0] txn_kind, txn_bytes;
  logic [2:0] txn_addr;
  logic [23:0] txn_wdata, conv_data;

  adc_cal_seq #(.CLK_HZ(HZ), .TMO_CYC(TMO), .CAL_CHANS(3)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_conf(cfg_conf), .cfg_io(cfg_io),
    .conv_req(conv_req), .conv_chan(conv_chan), .gain_req(gain_req), .gain_val(gain_val),
    .rdy_n(rdy_n), .txn_done(txn_done), .txn_err(txn_err), .txn_rdata(txn_rdata),
    .txn_valid(txn_valid), .txn_kind(txn_kind), .txn_addr(txn_addr),
    .txn_bytes(txn_bytes), .txn_wdata(txn_wdata), .ready(ready), .fault(fault),
    .wide(wide), .conv_done(conv_done), .conv_data(conv_data)
  );

  int n_run = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // engine model and transaction log
  logic [30:0] lg [128];
  int lt [128];
  int log_n = 0, done0_t = 0;
  logic [30:0] ex [128];
  int en = 0;
  logic [7:0] id_val = 8'h0B;
  logic [23:0] dval = '0;
  bit rdy_never = 0;
  int err_at = -1;
  bit eng_busy = 0;
  int lat = 0, rdy_cnt = 0, cur = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      log_n = 0; eng_busy = 0; txn_done = 0; txn_err = 0; rdy_n = 1; rdy_cnt = 0;
    end else begin
      if (rdy_cnt > 0) begin
        rdy_cnt = rdy_cnt - 1;
        if (rdy_cnt == 1 && !rdy_never) rdy_n = 0;
      end
      if (txn_done) begin
        txn_done = 0; txn_err = 0;
      end else if (txn_valid && !eng_busy) begin
        cur = log_n;
        if (log_n < 128) begin
          lg[log_n] = {txn_kind, txn_addr, txn_bytes, txn_wdata};
          lt[log_n] = cyc;
        end
        log_n = log_n + 1;
        if (txn_kind == 2'd1 && txn_addr == 3'd1 &&
            (txn_wdata[15:13] == 3'd1 || txn_wdata[15:13] == 3'd4 || txn_wdata[15:13] == 3'd5))
          rdy_cnt = 8;
        else begin
          rdy_n = 1; rdy_cnt = 0;
        end
        eng_busy = 1; lat = 2;
      end else if (eng_busy) begin
        lat = lat - 1;
        if (lat == 0) begin
          txn_rdata = (txn_kind != 2'd2) ? 24'h0 : (txn_addr == 3'd4) ? {16'h0, id_val} : dval;
          txn_err = (cur == err_at);
          txn_done = 1;
          if (cur == 0) done0_t = cyc;
          eng_busy = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // bench restatement of the word fields
  function automatic logic [15:0] bsel(logic [15:0] w, int c);
    return (w & 16'h1FFF) | 16'((c & 7) * 8192);
  endfunction
  function automatic logic [15:0] bchan(logic [15:0] w, int c);
    return (w & 16'hFFF8) | 16'(c & 7);
  endfunction
  function automatic logic [15:0] bgain(logic [15:0] w, int g);
    return (w & 16'hF8FF) | 16'((g & 7) * 256);
  endfunction

  logic [15:0] bmode, bconf;

  task automatic push(input int k, input int a, input int b, input logic [23:0] w);
    ex[en] = {2'(k), 3'(a), 2'(b), w};
    en++;
  endtask

  task automatic exp_cal();
    for (int s = 0; s < 6; s++) begin
      bconf = bchan(bconf, s / 2);     push(1, 2, 2, {8'h0, bconf});
      bmode = bsel(bmode, 4 + s % 2);  push(1, 1, 2, {8'h0, bmode});
      bmode = bsel(bmode, 2);          push(1, 1, 2, {8'h0, bmode});
    end
  endtask

  task automatic exp_init(input bit with_cal);
    push(0, 0, 0, 24'h0);
    push(2, 4, 1, 24'h0);
    bmode = bsel(cfg_mode, 2); push(1, 1, 2, {8'h0, bmode});
    bconf = bchan(cfg_conf, 0); push(1, 2, 2, {8'h0, bconf});
    push(1, 5, 1, {16'h0, cfg_io});
    if (with_cal) exp_cal();
  endtask

  task automatic exp_conv(input int ch, input bit w);
    bconf = bchan(bconf, ch);   push(1, 2, 2, {8'h0, bconf});
    bmode = bsel(bmode, 1);     push(1, 1, 2, {8'h0, bmode});
    push(2, 3, w ? 3 : 2, 24'h0);
  endtask

  task automatic check_log(input string req);
    chk(log_n == en, req, "transaction count", log_n, en);
    for (int i = 0; i < en && i < log_n && i < 128; i++)
      chk(lg[i] == ex[i], req, $sformatf("transaction %0d", i), {1'b0, lg[i]}, {1'b0, ex[i]});
  endtask

  task automatic start(input logic [7:0] id, input bit never, input int eat);
    rst_n = 0; id_val = id; rdy_never = never; err_at = eat;
    conv_req = 0; gain_req = 0; en = 0;
    repeat (3) @(negedge clk);
    chk(!txn_valid && !ready && !fault && !conv_done, "R9", "reset state",
        {28'h0, txn_valid, ready, fault, conv_done}, 32'h0);
    rst_n = 1;
  endtask

  task automatic settle();
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (ready || fault) break;
    end
  endtask

  task automatic conv(input int ch, input logic [23:0] d, input bit w);
    bit got;
    got = 0;
    dval = d;
    settle();
    conv_req = 1; conv_chan = 3'(ch);
    @(negedge clk);
    conv_req = 0;
    for (int i = 0; i < 500 && !got; i++) begin
      if (conv_done) begin
        got = 1;
        chk(conv_data == (w ? d : {8'h0, d[15:0]}), "R6", $sformatf("data ch%0d", ch),
            {8'h0, conv_data}, {8'h0, (w ? d : {8'h0, d[15:0]})});
      end else @(negedge clk);
    end
    chk(got, "R6", "conv_done pulse", {31'h0, got}, 32'h1);
    exp_conv(ch, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // run A: 24-bit part, full flow
    start(8'h0B, 0, -1);
    settle();
    chk(ready && !fault, "R9", "ready after calibration", {30'h0, ready, fault}, 32'h2);
    chk(wide == 1'b1, "R2", "wide for low nibble B", {31'h0, wide}, 32'h1);
    chk(lt[1] - done0_t >= DLY && lt[1] - done0_t <= DLY + 4, "R1", "settling gap",
        lt[1] - done0_t, DLY);
    exp_init(1);
    check_log("R3 R4 R5");
    for (int ch = 0; ch < 8; ch++) conv(ch, 24'h9C3A50 ^ 24'(ch * 24'h010203), 1);
    check_log("R6");
    @(negedge clk);
    gain_req = 1; gain_val = 3'd3;
    @(negedge clk);
    gain_req = 0;
    repeat (20) @(negedge clk);
    chk(ready, "R7", "ready after equal gain", {31'h0, ready}, 32'h1);
    check_log("R7 equal gain");
    gain_req = 1; gain_val = 3'd5;
    @(negedge clk);
    gain_req = 0; conv_req = 1; conv_chan = 3'd4;   // R9: ignored while busy
    @(negedge clk);
    conv_req = 0;
    bconf = bgain(bconf, 5); push(1, 2, 2, {8'h0, bconf});
    exp_cal();
    settle();
    check_log("R7 R9 new gain");
    conv(2, 24'h123456, 1);
    check_log("R6 after gain");

    // run B: 16-bit part
    start(8'h4A, 0, -1);
    settle();
    chk(wide == 1'b0, "R2", "wide for low nibble A", {31'h0, wide}, 32'h0);
    exp_init(1);
    conv(1, 24'hABCDEF, 0);
    check_log("R2 R6 16-bit");

    // run C: unknown identity
    start(8'h5C, 0, -1);
    settle();
    chk(fault && !ready, "R2", "fault on bad id", {30'h0, fault, ready}, 32'h2);
    push(0, 0, 0, 24'h0); push(2, 4, 1, 24'h0);
    conv_req = 1; conv_chan = 3'd0;
    @(negedge clk);
    conv_req = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (conv_done) chk(0, "R8", "conv_done in fault", 1, 0);
    end
    chk(fault, "R8", "fault sticky", {31'h0, fault}, 32'h1);
    check_log("R2 R8 bad id");

    // run D: ready line never falls
    start(8'h0B, 1, -1);
    settle();
    chk(fault && !ready, "R8", "fault on ready timeout", {30'h0, fault, ready}, 32'h2);
    exp_init(0);
    bconf = bchan(bconf, 0); push(1, 2, 2, {8'h0, bconf});
    bmode = bsel(bmode, 4);  push(1, 1, 2, {8'h0, bmode});
    check_log("R8 timeout");

    // run E: engine error on the fourth transaction
    start(8'h0B, 0, 3);
    settle();
    chk(fault, "R8", "fault on engine error", {31'h0, fault}, 32'h1);
    push(0, 0, 0, 24'h0); push(2, 4, 1, 24'h0);
    bmode = bsel(cfg_mode, 2); push(1, 1, 2, {8'h0, bmode});
    bconf = bchan(cfg_conf, 0); push(1, 2, 2, {8'h0, bconf});
    repeat (10) @(negedge clk);
    check_log("R8 engine error");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule